// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM whose bus can carry a read or a write on every clock, in any mix and order, with no dead cycles when the direction changes. Every control, address and byte-enable input is registered on the rising edge. Read data comes out one enabled edge after the address. Write data is taken from the bus one enabled edge later than that, so read data and write data use the bus in the same pipeline slot and never collide.

A write whose data has not yet reached the array can be followed at once by a read of the same word. The read returns the new bytes merged with the old ones. Accesses start from an external address or continue a four-word burst from an internal 2-bit counter, in linear or interleaved order. A clock-enable pin freezes the whole pipeline. The memory is split into byte lanes of 9 bits, four lanes per word by default, and has 256 words by default. The shared data bus is modelled as a separate input and output plus an output-enable flag. The bus has no valid/ready handshake: the clock enable is the only way to stall it.

Top module: `zbt_sram`

## Requirements
- R1: When a read is accepted at enabled edge k, the word stored at its address appears on `dq_out` with `dq_oe` high after the next enabled edge.
- R2: For a write accepted at enabled edge k, `dq_in` is sampled at the second enabled edge after k. Only byte lanes whose `bw_n` bit was low at edge k change. Lane i is bits 9i+8 down to 9i.
- R3: Reads and writes can be issued on consecutive enabled edges in any order with no idle cycle, and each returns or stores the correct data.
- R4: While `cke_n` is high, all synchronous inputs are ignored. `dq_out` and `dq_oe` hold their values, and no access advances through the pipeline.
- R5: When an access is loaded, `rw_n` low selects a write and `rw_n` high selects a read.
- R6: An access starts only when `adv_ld` is low, `cs0_n` is low, `cs1` is high and `cs2_n` is low. Any other chip-select combination with `adv_ld` low is a deselect: it writes nothing, and `dq_oe` is low in its output slot.
- R7: With `adv_ld` high, the previous access type continues and `rw_n`, the chip selects and `addr` are ignored. For continuation n (1 to 3, wrapping modulo 4), the two low address bits are base+n modulo 4 when `burst_mode` is 0, and base XOR n when `burst_mode` is 1. The upper address bits are unchanged.
- R8: A continuation (`adv_ld` high) after a deselect stays deselected: no write, and `dq_oe` is low.
- R9: A read of a word whose write data is still in the pipeline returns the newly written bytes merged with the stored ones.
- R10: `dq_oe` is low in the output slot of every write and every deselect.
- R11: Reset clears the pipeline and drives `dq_oe` low. Array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state |
| cke_n | input | 1 | Clock enable, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | Low: load a new access; high: continue the burst |
| rw_n | input | 1 | Access type on load, low means write |
| burst_mode | input | 1 | Burst order, 1 interleaved, 0 linear |
| bw_n | input | NB | Per-lane write enables, active low |
| addr | input | AW | Word address |
| dq_in | input | NB*LW | Write data, bus in-direction |
| dq_out | output | NB*LW | Read data, bus out-direction |
| dq_oe | output | 1 | High when `dq_out` carries read data |

## Verification
The hardest situation to reach from the ports is a read that hits a write whose data is still in flight. It gets harder when a clock-enable stall falls between the write's address and its data, or when the read comes out of a burst whose computed address lands on the pending word. The stimulus runs long stretches of mixed reads, partial-lane writes and random stalls over an address window of only eight words, so that hits are frequent. It also runs directed write-then-read pairs and write bursts read back in the other burst order. A behavioural model holds a two-entry history of accepted accesses and checks every cycle.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address bits of a burst beat
  function automatic logic [BURST_W-1:0] burst_lane(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] step,
    input logic               interleave
  );
    return interleave ? (base ^ step) : (base + step);
  endfunction

endpackage

// File: rtl/zbt_cmd_seq.sv
module zbt_cmd_seq
  import zbt_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cs0_n,
  input  logic          cs1,
  input  logic          cs2_n,
  input  logic          adv_ld,
  input  logic          rw_n,
  input  logic          burst_mode,
  input  logic [NB-1:0] bw_n,
  input  logic [AW-1:0] addr,
  output op_e           s1_op,
  output logic [AW-1:0] s1_addr,
  output logic [NB-1:0] s1_be
);

  logic                sel;
  op_e                 nxt_op;
  logic [AW-1:0]       base_q, nxt_base;
  logic [BURST_W-1:0]  step_q, nxt_step;
  logic [AW-1:0]       eff_addr;

  assign sel = !cs0_n && cs1 && !cs2_n;

  always_comb begin
    if (!adv_ld) begin
      nxt_op   = sel ? (rw_n ? OP_RD : OP_WR) : OP_NONE;
      nxt_base = addr;
      nxt_step = '0;
    end else begin
      nxt_op   = s1_op;
      nxt_base = base_q;
      nxt_step = (s1_op != OP_NONE) ? step_q + 1'b1 : step_q;
    end
    eff_addr = {nxt_base[AW-1:BURST_W],
                burst_lane(nxt_base[BURST_W-1:0], nxt_step, burst_mode)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_NONE;
      base_q  <= '0;
      step_q  <= '0;
      s1_addr <= '0;
      s1_be   <= '0;
    end else if (en) begin
      s1_op   <= nxt_op;
      base_q  <= nxt_base;
      step_q  <= nxt_step;
      s1_addr <= eff_addr;
      s1_be   <= ~bw_n;
    end
  end

endmodule

// File: rtl/zbt_wr_track.sv
module zbt_wr_track
  import zbt_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  op_e              s1_op,
  input  logic [AW-1:0]    s1_addr,
  input  logic [NB-1:0]    s1_be,
  input  logic [NB*LW-1:0] dq_in,
  input  logic [NB*LW-1:0] core_rdata,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [NB-1:0]    wr_be,
  output logic [NB*LW-1:0] rd_merged
);

  op_e           s2_op;
  logic [AW-1:0] s2_addr;
  logic [NB-1:0] s2_be;
  logic          hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op   <= OP_NONE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (en) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  assign wr_en   = en && (s2_op == OP_WR);
  assign wr_addr = s2_addr;
  assign wr_be   = s2_be;
  assign hit     = (s2_op == OP_WR) && (s2_addr == s1_addr);

  for (genvar g = 0; g < NB; g++) begin : g_fwd
    assign rd_merged[g*LW +: LW] = (hit && s2_be[g]) ? dq_in[g*LW +: LW]
                                                     : core_rdata[g*LW +: LW];
  end

endmodule

// File: rtl/zbt_core.sv
module zbt_core #(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NB-1:0]    wbe,
  input  logic [NB*LW-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [NB*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wbe[g]) mem[waddr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = mem[raddr];
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4,
  parameter int LW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             adv_ld,
  input  logic             rw_n,
  input  logic             burst_mode,
  input  logic [NB-1:0]    bw_n,
  input  logic [AW-1:0]    addr,
  input  logic [NB*LW-1:0] dq_in,
  output logic [NB*LW-1:0] dq_out,
  output logic             dq_oe
);

  localparam int DW = NB * LW;

  logic          en;
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic [NB-1:0] s1_be;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [NB-1:0] wr_be;
  logic [DW-1:0] core_rdata, rd_merged;

  assign en = !cke_n;

  zbt_cmd_seq #(.AW(AW), .NB(NB)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .adv_ld(adv_ld), .rw_n(rw_n), .burst_mode(burst_mode),
    .bw_n(bw_n), .addr(addr),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be)
  );

  zbt_wr_track #(.AW(AW), .NB(NB), .LW(LW)) u_trk (
    .clk(clk), .rst_n(rst_n), .en(en),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
    .dq_in(dq_in), .core_rdata(core_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .rd_merged(rd_merged)
  );

  zbt_core #(.AW(AW), .NB(NB), .LW(LW)) u_core (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wbe(wr_be),
    .wdata(dq_in), .raddr(s1_addr), .rdata(core_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else if (en) begin
      dq_oe <= (s1_op == OP_RD);
      if (s1_op == OP_RD) dq_out <= rd_merged;
    end
  end

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          cs0_n,
  input logic          cs1,
  input logic          cs2_n,
  input logic          adv_ld,
  input logic          rw_n,
  input logic          dq_oe,
  input logic [DW-1:0] dq_out
);

  logic sel;
  assign sel = !cs0_n && cs1 && !cs2_n;

  a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && sel && rw_n) ##1 !cke_n |=> dq_oe);

  a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && sel && !rw_n) ##1 !cke_n |=> !dq_oe);

  a_r6_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && !sel) ##1 !cke_n |=> !dq_oe);

  a_r8_no_burst_revive: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !adv_ld && !sel) ##1 (!cke_n && adv_ld) ##1 !cke_n |=> !dq_oe);

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(dq_oe) && $stable(dq_out)));

  always @(negedge clk) begin
    if (!rst_n) a_r11_reset_quiet: assert (!dq_oe);
  end

endmodule

bind zbt_sram zbt_sram_chk #(.DW(NB*LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
  .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
  .adv_ld(adv_ld), .rw_n(rw_n),
  .dq_oe(dq_oe), .dq_out(dq_out)
);

// File: tb/sim_zbt_sram.sv
module sim_zbt_sram;

  typedef struct {
    int          kind;   // 0 none, 1 read, 2 write
    int          addr;
    logic [3:0]  be;
    logic [35:0] data;
  } op_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke_n = 1'b1;
  logic        cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
  logic        adv_ld = 1'b0, rw_n = 1'b1, burst_mode = 1'b0;
  logic [3:0]  bw_n = 4'hF;
  logic [7:0]  addr = '0;
  logic [35:0] dq_in = '0;
  logic [35:0] dq_out;
  logic        dq_oe;

  int checks = 0, fails = 0, cycles = 0;
  logic [35:0] mem [256];
  op_t hist[$];
  int bkind = 0, bbase = 0, bcnt = 0;
  logic        exp_oe = 1'b0;
  logic [35:0] exp_out = '0;

  always #4 clk = ~clk;

  zbt_sram u0 (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .adv_ld(adv_ld), .rw_n(rw_n), .burst_mode(burst_mode),
    .bw_n(bw_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: model the coming edge, then compare after it
  task automatic step(input string req, input logic [35:0] wd);
    op_t n;
    int lo;
    if (hist.size() == 2 && hist[0].kind == 2) dq_in = hist[0].data;
    else dq_in = {4'($urandom), 32'($urandom)};
    if (!cke_n) begin
      if (hist.size() == 2 && hist[0].kind == 2)
        for (int b = 0; b < 4; b++)
          if (hist[0].be[b]) mem[hist[0].addr][b*9 +: 9] = hist[0].data[b*9 +: 9];
      if (hist.size() > 0 && hist[hist.size()-1].kind == 1) begin
        exp_oe = 1'b1;
        exp_out = mem[hist[hist.size()-1].addr];
      end else exp_oe = 1'b0;
      if (!adv_ld) begin
        bkind = (!cs0_n && cs1 && !cs2_n) ? (rw_n ? 1 : 2) : 0;
        bbase = int'(addr);
        bcnt = 0;
      end else if (bkind != 0) bcnt = (bcnt + 1) % 4;
      lo = burst_mode ? ((bbase % 4) ^ bcnt) : ((bbase % 4 + bcnt) % 4);
      n.kind = bkind;
      n.addr = (bbase / 4) * 4 + lo;
      n.be = ~bw_n;
      n.data = wd;
      hist.push_back(n);
      if (hist.size() > 2) void'(hist.pop_front());
    end
    @(posedge clk);
    @(negedge clk);
    chk(dq_oe === exp_oe, {req, " oe"}, 36'(dq_oe), 36'(exp_oe));
    if (exp_oe) chk(dq_out === exp_out, {req, " data"}, dq_out, exp_out);
  endtask

  task automatic load(input int kind, input int a, input logic [3:0] be, input logic [35:0] wd, input string req);
    cke_n = 1'b0; adv_ld = 1'b0;
    {cs0_n, cs1, cs2_n} = (kind == 0) ? 3'b100 : 3'b010;
    rw_n = (kind != 2);
    addr = 8'(a); bw_n = ~be;
    step(req, wd);
  endtask

  task automatic cont(input logic [3:0] be, input logic [35:0] wd, input string req);
    cke_n = 1'b0; adv_ld = 1'b1;
    {cs0_n, cs1, cs2_n} = 3'($urandom); rw_n = 1'($urandom); addr = 8'($urandom);
    bw_n = ~be;
    step(req, wd);
  endtask

  task automatic stall(input string req);
    cke_n = 1'b1;
    adv_ld = 1'($urandom); rw_n = 1'($urandom); addr = 8'($urandom);
    {cs0_n, cs1, cs2_n} = 3'($urandom); bw_n = 4'($urandom);
    step(req, '0);
  endtask

  task automatic do_reset(input string req);
    rst_n = 1'b0; cke_n = 1'b0;
    {cs0_n, cs1, cs2_n} = 3'b100; adv_ld = 1'b0;
    repeat (2) @(negedge clk);
    hist.delete(); bkind = 0; exp_oe = 1'b0;
    chk(dq_oe === 1'b0, {req, " oe in reset"}, 36'(dq_oe), 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0, {req, " oe after reset"}, 36'(dq_oe), 36'd0);
  endtask

  function automatic logic [35:0] rnd36();
    return {4'($urandom), 32'($urandom)};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 'x;
    repeat (3) @(negedge clk);
    do_reset("R11");

    // R2: fill every word with full-lane writes, back to back
    for (int a = 0; a < 256; a++) load(2, a, 4'hF, rnd36(), "R2");
    load(0, 0, 4'hF, '0, "R6"); load(0, 0, 4'hF, '0, "R6");

    // R1: read every word back
    for (int a = 0; a < 256; a++) load(1, a, 4'hF, '0, "R1");

    // R9: write then immediate read of same word, full and partial lanes
    load(2, 40, 4'hF, rnd36(), "R9"); load(1, 40, 4'hF, '0, "R9");
    load(2, 40, 4'b0101, rnd36(), "R9"); load(1, 40, 4'hF, '0, "R9");
    load(2, 41, 4'b1000, rnd36(), "R9"); load(2, 41, 4'b0001, rnd36(), "R9");
    load(1, 41, 4'hF, '0, "R9"); load(1, 41, 4'hF, '0, "R9");

    // R3 / R5: strict alternation and random mixes without idle cycles
    for (int i = 0; i < 60; i++) load((i % 2) ? 1 : 2, i % 8, 4'($urandom), rnd36(), "R3");
    for (int i = 0; i < 150; i++)
      load(1 + int'($urandom_range(0, 1)), int'($urandom_range(0, 7)), 4'($urandom), rnd36(), "R5");

    // R4: random stalls, including inside write address-to-data gaps
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 3) == 0) stall("R4");
      else load(1 + int'($urandom_range(0, 1)), int'($urandom_range(0, 7)), 4'($urandom), rnd36(), "R4");
    end
    load(2, 3, 4'hF, rnd36(), "R4"); stall("R4"); stall("R4"); load(1, 3, 4'hF, '0, "R4");
    stall("R4"); load(1, 3, 4'hF, '0, "R4"); stall("R4"); stall("R4");

    // R6: each chip select alone can turn a write into a deselect
    for (int s = 0; s < 3; s++) begin
      cke_n = 1'b0; adv_ld = 1'b0; rw_n = 1'b0; addr = 8'(60 + s); bw_n = 4'h0;
      {cs0_n, cs1, cs2_n} = 3'b010 ^ (3'b100 >> s);
      step("R6", rnd36());
    end
    load(0, 0, 4'hF, '0, "R6");
    for (int s = 0; s < 3; s++) load(1, 60 + s, 4'hF, '0, "R6");

    // R7: bursts in both orders, read back in the other order
    for (int m = 0; m < 2; m++) begin
      burst_mode = m[0];
      load(2, 8'h12 + 8 * m, 4'hF, rnd36(), "R7");
      for (int k = 0; k < 3; k++) cont(4'hF, rnd36(), "R7");
      burst_mode = ~m[0];
      load(1, 8'h12 + 8 * m, 4'hF, '0, "R7");
      for (int k = 0; k < 3; k++) cont(4'hF, '0, "R7");
      burst_mode = m[0];
      load(1, 8'h13 + 8 * m, 4'hF, '0, "R7");
      for (int k = 0; k < 4; k++) cont(4'hF, '0, "R7");
    end
    burst_mode = 1'b0;

    // R8: continuation after deselect neither reads nor writes
    load(0, 70, 4'hF, '0, "R8");
    for (int k = 0; k < 4; k++) begin rw_n = 1'b0; cont(4'hF, rnd36(), "R8"); end
    for (int a = 68; a < 72; a++) load(1, a, 4'hF, '0, "R8");

    // R10: writes and deselects interleaved with reads
    for (int i = 0; i < 40; i++) load(i % 3, int'($urandom_range(0, 255)), 4'($urandom), rnd36(), "R10");

    // R11: reset mid-run keeps array contents
    load(0, 0, 4'hF, '0, "R11"); load(0, 0, 4'hF, '0, "R11");
    do_reset("R11");
    cont(4'hF, '0, "R11");
    load(1, 40, 4'hF, '0, "R11"); load(1, 200, 4'hF, '0, "R11");
    load(0, 0, 4'hF, '0, "R11"); load(0, 0, 4'hF, '0, "R11");

    summary();
    $finish;
  end

endmodule